// File: doc/BRIEF.md
# Audio Link Capture-Frame Serializer

This block is the codec-side transmitter of the serial line that carries recorded audio, status and register read answers from a codec to its controller. The clock is the link bit clock. A rising edge on the frame sync input starts a new frame. The block then builds a 256-bit frame and shifts it out most significant bit first on one serial data pin. A frame is a 16-bit tag phase followed by twelve 20-bit slots.

Register read answers and the left and right record samples arrive as one-cycle strobes. Each strobe loads a hold register, which is emptied when the next frame starts. A value captured during one frame is therefore sent in the frame that follows, and never in the frame that is already on the wire.

The tag reports codec readiness and marks which slots carry valid data. Slot 1 carries the echoed register index and two active-low requests that ask the controller for samples. Slot 2 carries the read data. Slots 3 and 4 carry the 18-bit samples left-justified in the 20-bit slot. All other positions are sent as zeros.

Each hold register is a two-state machine. `HOLD_EMPTY` moves to `HOLD_FULL` on a strobe. `HOLD_FULL` moves back to `HOLD_EMPTY` at a frame start when no strobe arrives in the same cycle. A strobe in that cycle keeps it in `HOLD_FULL` with the new value.

The shifter has two states. `SH_IDLE` moves to `SH_SHIFT` on a sync rising edge. `SH_SHIFT` returns to `SH_IDLE` after the last of the 256 bits. A new sync rising edge while in `SH_SHIFT` restarts the frame.

Top module: `link_in_serializer`

## Requirements
- R1: After reset the serial output is 0, and it stays 0 until the first rising edge of sync.
- R2: A rising sync edge seen at a bit-clock edge starts a frame. The frame's 256 bits leave MSB first, one per clock, starting right after that edge. After the last bit the output is 0 until the next rising sync. A sync held high does not start a second frame.
- R3: Tag bit 15 (the first bit of the frame) equals the codec-ready input sampled at the frame-start edge.
- R4: A read strobe captures the register index and read data. They appear in the next frame that starts after the capture: index in slot 1 bits 18:12, data in slot 2 bits 19:4, and tag bits 14 and 13 set. A strobe at the same edge as a frame start belongs to the following frame. Each capture is sent exactly once.
- R5: When no read answer is pending, tag bits 14 and 13 are 0. Slot 1 bits 18:12 are 0 and all of slot 2 is 0.
- R6: Slot 1 bit 11 is the inverse of the need-left input and bit 10 is the inverse of the need-right input, both sampled at frame start. A value of 0 requests a sample.
- R7: A left or right sample strobe captures an 18-bit sample. That sample is sent in the next frame in slot 3 (left) or slot 4 (right), bits 19:2, with bits 1:0 zero and tag bit 12 (left) or 11 (right) set. Otherwise the slot and its tag bit are zero.
- R8: Tag bits 10:0 are 0, slot 1 bits 19 and 9:0 are 0, and slots 5 to 12 are entirely 0.
- R9: A frame's contents are fixed at its start edge. Input changes during the frame do not alter the bits still to be sent.
- R10: A rising sync during a frame aborts it. The new frame starts from its tag bit 15 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame sync; a rising edge starts a frame |
| codec_ready | input | 1 | Codec ready flag for the tag |
| need_left | input | 1 | Codec wants a left sample in the next output frame |
| need_right | input | 1 | Codec wants a right sample in the next output frame |
| rd_strobe | input | 1 | Read answer strobe |
| rd_addr | input | 7 | Register index being answered |
| rd_data | input | 16 | Register read data |
| left_strobe | input | 1 | Left record sample strobe |
| left_sample | input | 18 | Left record sample |
| right_strobe | input | 1 | Right record sample strobe |
| right_sample | input | 18 | Right record sample |
| sdata | output | 1 | Serial frame data, changes after the rising clock edge |

## Verification
On every cycle the assertions check the following:
- a frame start loads the shifter and makes the first bit equal the ready flag;
- the shift register moves by exactly one bit per clock;
- the shifter falls idle after the 256th bit;
- a hold register fills on its strobe and drains at a frame start.

Only the bench scenarios can show the end-to-end behaviour. These cover the packed positions of every field, and the one-frame delay of read answers and samples, including a strobe that coincides with the sync edge. They also cover zero stuffing when nothing is pending, immunity to input changes in mid-frame, a sync held high, and the abort-and-restart on an early sync.

// File: rtl/link_pkg.sv
package link_pkg;

    // Fill state of a one-entry capture register
    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_e;

    // Serializer sequencing
    typedef enum logic {
        SH_IDLE  = 1'b0,
        SH_SHIFT = 1'b1
    } shift_state_e;

    // Number of tag bits with a defined meaning (ready + four valid flags)
    localparam int TAG_USED = 5;

    // Slot 1 layout: reserved MSB, index, two request bits, then zero fill
    localparam int SLOT1_FIXED = 3;

endpackage

// File: rtl/link_hold.sv
module link_hold
    import link_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             take,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    output logic [WIDTH-1:0] dout
);

    hold_state_e state_q, state_d;
    logic [WIDTH-1:0] data_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_EMPTY: if (load) state_d = HOLD_FULL;
            HOLD_FULL:  if (take && !load) state_d = HOLD_EMPTY;
            default:    state_d = HOLD_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_EMPTY;
        else        state_q <= state_d;
    end

    // Payload register: every strobe overwrites the held value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= din;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            HOLD_FULL: full = 1'b1;
            default:   full = 1'b0;
        endcase
        dout = data_q;
    end

    // R4 / R7: a strobe is captured and marked pending
    assert_hold_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (full && dout == $past(din)));

    // R7: a frame start with no new strobe empties the hold
    assert_hold_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !load) |=> !full);

    // R4: an idle hold with no strobe stays empty
    assert_hold_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && !load) |=> !full);

endmodule

// File: rtl/link_frame_build.sv
module link_frame_build
    import link_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 16,
    parameter int SAMPLE_W  = 18,
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12,
    localparam int FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                codec_ready,
    input  logic                need_left,
    input  logic                need_right,
    input  logic                rd_strobe,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic                left_strobe,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic                right_strobe,
    input  logic [SAMPLE_W-1:0] right_sample,
    output logic [FRAME_W-1:0]  frame_word
);

    localparam int RD_W      = ADDR_W + DATA_W;
    localparam int S1_FILL   = SLOT_W - SLOT1_FIXED - ADDR_W;
    localparam int S2_FILL   = SLOT_W - DATA_W;
    localparam int SMP_FILL  = SLOT_W - SAMPLE_W;
    localparam int TAG_FILL  = TAG_W - TAG_USED;

    logic              rd_full, left_full, right_full;
    logic [RD_W-1:0]   rd_held;
    logic [SAMPLE_W-1:0] left_held, right_held;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_data;
    logic [TAG_W-1:0]  tag_val;
    logic [SLOT_W-1:0] slot_val [NUM_SLOTS];

    link_hold #(.WIDTH(RD_W)) u_rd_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_strobe),
        .take  (frame_start),
        .din   ({rd_addr, rd_data}),
        .full  (rd_full),
        .dout  (rd_held)
    );

    link_hold #(.WIDTH(SAMPLE_W)) u_left_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (left_strobe),
        .take  (frame_start),
        .din   (left_sample),
        .full  (left_full),
        .dout  (left_held)
    );

    link_hold #(.WIDTH(SAMPLE_W)) u_right_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (right_strobe),
        .take  (frame_start),
        .din   (right_sample),
        .full  (right_full),
        .dout  (right_held)
    );

    assign held_addr = rd_held[RD_W-1:DATA_W];
    assign held_data = rd_held[DATA_W-1:0];

    // Tag phase: ready, then valid flags for slots 1..4, zero fill
    always_comb begin
        tag_val = {codec_ready, rd_full, rd_full, left_full, right_full,
                   {TAG_FILL{1'b0}}};
    end

    // Slot contents; anything not listed stays zero
    always_comb begin
        for (int k = 0; k < NUM_SLOTS; k++) slot_val[k] = '0;
        slot_val[0] = {1'b0,
                       rd_full ? held_addr : {ADDR_W{1'b0}},
                       ~need_left, ~need_right,
                       {S1_FILL{1'b0}}};
        if (rd_full)    slot_val[1] = {held_data,  {S2_FILL{1'b0}}};
        if (left_full)  slot_val[2] = {left_held,  {SMP_FILL{1'b0}}};
        if (right_full) slot_val[3] = {right_held, {SMP_FILL{1'b0}}};
    end

    // Place tag and slots into the frame, MSB first
    assign frame_word[FRAME_W-1 -: TAG_W] = tag_val;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            assign frame_word[FRAME_W-TAG_W-1-g*SLOT_W -: SLOT_W] = slot_val[g];
        end
    endgenerate

    // R5: with nothing pending, the read valid flags drop after a frame start
    assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !rd_strobe) |=> (frame_word[FRAME_W-2] == 1'b0));

    // R7: a sample strobe raises its valid tag on the next cycle
    assert_left_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        left_strobe |=> frame_word[FRAME_W-4]);

endmodule

// File: rtl/link_frame_shift.sv
module link_frame_shift
    import link_pkg::*;
#(
    parameter int FRAME_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync,
    input  logic [FRAME_W-1:0] frame_word,
    output logic               frame_start,
    output logic               sdata
);

    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    shift_state_e       state_q, state_d;
    logic               sync_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;

    assign frame_start = sync & ~sync_q;

    // Sync edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE: begin
                if (frame_start) state_d = SH_SHIFT;
            end
            SH_SHIFT: begin
                if (frame_start)          state_d = SH_SHIFT;
                else if (cnt_q == LAST_BIT) state_d = SH_IDLE;
            end
            default: state_d = SH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    // Frame snapshot and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (frame_start) begin
            shreg_q <= frame_word;
            cnt_q   <= '0;
        end else if (state_q == SH_SHIFT) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            cnt_q   <= cnt_q + CNT_ONE;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            SH_SHIFT: sdata = shreg_q[FRAME_W-1];
            default:  sdata = 1'b0;
        endcase
    end

    // R10: any sync rising edge restarts at bit zero of the frame
    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state_q == SH_SHIFT && cnt_q == '0));

    // R2: the machine goes idle after the final bit
    assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_SHIFT && cnt_q == LAST_BIT && !frame_start) |=> state_q == SH_IDLE);

    // R9: mid-frame the snapshot only moves by one bit
    assert_shift_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_SHIFT && !frame_start) |=>
            shreg_q == {$past(shreg_q[FRAME_W-2:0]), 1'b0});

    // R1: without a sync edge an idle shifter stays idle
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_IDLE && !frame_start) |=> state_q == SH_IDLE);

endmodule

// File: rtl/link_in_serializer.sv
module link_in_serializer
    import link_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 16,
    parameter int SAMPLE_W  = 18,
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync,
    input  logic                codec_ready,
    input  logic                need_left,
    input  logic                need_right,
    input  logic                rd_strobe,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic                left_strobe,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic                right_strobe,
    input  logic [SAMPLE_W-1:0] right_sample,
    output logic                sdata
);

    localparam int FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;

    logic               frame_start;
    logic [FRAME_W-1:0] frame_word;

    link_frame_build #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SAMPLE_W  (SAMPLE_W),
        .TAG_W     (TAG_W),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_build (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .codec_ready  (codec_ready),
        .need_left    (need_left),
        .need_right   (need_right),
        .rd_strobe    (rd_strobe),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .left_strobe  (left_strobe),
        .left_sample  (left_sample),
        .right_strobe (right_strobe),
        .right_sample (right_sample),
        .frame_word   (frame_word)
    );

    link_frame_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync        (sync),
        .frame_word  (frame_word),
        .frame_start (frame_start),
        .sdata       (sdata)
    );

    // R3: the first bit after a frame start is the sampled ready flag
    assert_ready_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> sdata == $past(codec_ready));

endmodule

// File: tb/link_in_serializer_test.sv
module link_in_serializer_test;

    localparam int FW = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        codec_ready = 1'b0;
    logic        need_left = 1'b0;
    logic        need_right = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data = '0;
    logic        left_strobe = 1'b0;
    logic [17:0] left_sample = '0;
    logic        right_strobe = 1'b0;
    logic [17:0] right_sample = '0;
    logic        sdata;

    int n_checks = 0;
    int n_fail = 0;
    bit mon_busy = 0;
    event ev_frame;
    logic [FW-1:0] exp_q [$];

    // Bench model of pending captures
    bit          m_rp = 0, m_lp = 0, m_rrp = 0;
    logic [6:0]  m_addr = '0;
    logic [15:0] m_data = '0;
    logic [17:0] m_left = '0, m_right = '0;

    always #5 clk = ~clk;

    link_in_serializer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync         (sync),
        .codec_ready  (codec_ready),
        .need_left    (need_left),
        .need_right   (need_right),
        .rd_strobe    (rd_strobe),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .left_strobe  (left_strobe),
        .left_sample  (left_sample),
        .right_strobe (right_strobe),
        .right_sample (right_sample),
        .sdata        (sdata)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] expect_frame();
        logic [15:0] tag;
        logic [19:0] s1, s2, s3, s4;
        tag = {codec_ready, m_rp, m_rp, m_lp, m_rrp, 11'b0};
        s1  = {1'b0, m_rp ? m_addr : 7'h0, ~need_left, ~need_right, 10'b0};
        s2  = m_rp  ? {m_data, 4'b0}  : 20'h0;
        s3  = m_lp  ? {m_left, 2'b0}  : 20'h0;
        s4  = m_rrp ? {m_right, 2'b0} : 20'h0;
        return {tag, s1, s2, s3, s4, 160'b0};
    endfunction

    // Driver: push the expected frame and raise sync
    task automatic start_frame(input bit with_read, input logic [6:0] a,
                               input logic [15:0] d, input bit hold);
        @(negedge clk);
        exp_q.push_back(expect_frame());
        m_rp = 0; m_lp = 0; m_rrp = 0;
        if (with_read) begin
            rd_addr = a; rd_data = d; rd_strobe = 1'b1;
            m_rp = 1; m_addr = a; m_data = d;
        end
        mon_busy = 1;
        sync = 1'b1;
        -> ev_frame;
        @(negedge clk);
        rd_strobe = 1'b0;
        if (!hold) sync = 1'b0;
    endtask

    task automatic put_read(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        rd_addr = a; rd_data = d; rd_strobe = 1'b1;
        m_rp = 1; m_addr = a; m_data = d;
        @(negedge clk);
        rd_strobe = 1'b0;
        rd_addr = ~a; rd_data = ~d;
    endtask

    task automatic put_left(input logic [17:0] s);
        @(negedge clk);
        left_sample = s; left_strobe = 1'b1; m_lp = 1; m_left = s;
        @(negedge clk);
        left_strobe = 1'b0; left_sample = ~s;
    endtask

    task automatic put_right(input logic [17:0] s);
        @(negedge clk);
        right_sample = s; right_strobe = 1'b1; m_rrp = 1; m_right = s;
        @(negedge clk);
        right_strobe = 1'b0; right_sample = ~s;
    endtask

    // Monitor: collect one frame and compare field by field
    always begin
        logic [FW-1:0] got, exp;
        @(ev_frame);
        @(negedge clk);
        for (int i = FW - 1; i >= 0; i--) begin
            got[i] = sdata;
            @(negedge clk);
        end
        exp = exp_q.pop_front();
        check(got[255:240] == exp[255:240], "R3 R9 tag",
              32'(got[255:240]), 32'(exp[255:240]));
        check(got[239:220] == exp[239:220], "R4 R5 R6 slot1",
              32'(got[239:220]), 32'(exp[239:220]));
        check(got[219:200] == exp[219:200], "R4 R5 slot2",
              32'(got[219:200]), 32'(exp[219:200]));
        check(got[199:160] == exp[199:160], "R7 slot3/4",
              got[191:160], exp[191:160]);
        check(got[159:0] == '0, "R8 slots5-12",
              32'($countones(got[159:0])), 32'h0);
        check(sdata == 1'b0, "R2 idle after frame", 32'(sdata), 32'h0);
        mon_busy = 0;
    end

    task automatic wait_frame();
        wait (mon_busy == 0);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: quiet through and after reset
        repeat (3) @(negedge clk);
        check(sdata == 1'b0, "R1 in reset", 32'(sdata), 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(sdata == 1'b0, "R1 after reset", 32'(sdata), 32'h0);
        end

        // Frame A: nothing pending, not ready, no requests (R5, R6)
        start_frame(0, '0, '0, 0);
        put_read(7'h1A, 16'hBEEF);
        put_left(18'h2ABCD);
        put_right(18'h15432);
        codec_ready = 1'b1;          // R9: mid-frame change must not show
        need_left   = 1'b1;
        wait_frame();

        // Frame B: read answer and both samples from the previous frame (R4, R7)
        start_frame(0, '0, '0, 0);
        wait_frame();

        // Frame C: each capture is sent only once (R4, R5)
        start_frame(0, '0, '0, 0);
        put_left(18'h3FFFF);
        need_right = 1'b1;
        need_left  = 1'b0;
        wait_frame();

        // Frame D: read strobe at the sync edge goes to the next frame (R4)
        start_frame(1, 7'h7F, 16'hFFFF, 0);
        wait_frame();

        // Frame E: carries the read captured at the start of D (R4)
        start_frame(0, '0, '0, 0);
        put_right(18'h00001);
        wait_frame();

        // Frame F: sync held high gives a single frame (R2)
        start_frame(0, '0, '0, 1);
        wait_frame();
        for (int i = 0; i < 40; i++) begin
            check(sdata == 1'b0, "R2 sync held high", 32'(sdata), 32'h0);
            @(negedge clk);
        end
        sync = 1'b0;
        repeat (3) @(negedge clk);

        // R10: early sync restarts the frame from its tag
        codec_ready = 1'b1;
        need_left = 1'b0; need_right = 1'b0;
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        repeat (40) @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        begin
            logic [15:0] tg;
            for (int i = 15; i >= 0; i--) begin
                tg[i] = sdata;
                @(negedge clk);
            end
            check(tg == 16'h8000, "R10 restart tag", 32'(tg), 32'h8000);
        end
        repeat (250) @(negedge clk);
        check(sdata == 1'b0, "R10 restarted frame ends", 32'(sdata), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule